// File: doc/BRIEF.md
# Programmable IO Address Window Decoder

This block holds a bank of address windows that software programs through a 32-bit register port. It routes each 48-bit physical address to a small target identifier. Each window has a lower-bound register, an upper-bound register and a target register. One global register supplies the identifier used when no window claims the address. Bounds are kept at 1 MB granularity. Address bits [47:20] are stored in register bits [31:4], bit 0 of the lower-bound register enables the window, and both bounds are inclusive.

A lookup port accepts an address with a valid strobe. One clock later it returns a hit flag and the selected target. When several enabled windows overlap, the lowest-numbered window wins. Window 0 is fixed at its boot-time programming and ignores writes. Every other register reads back exactly what was written, so software can save the whole map and later restore it.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, windows 1 to N-1 hold zero in all three registers and are therefore disabled, the global register holds 0, `lk_done`, `lk_hit`, `lk_tgt` and `reg_rdata` are 0, and an address that misses window 0 returns hit 0 with target 0.
- R2: The registers of window w sit at byte offset w*0x10: lower bound at +0x0, upper bound at +0x8, target at +0xC. The global register sits at N*0x10. A read with `reg_rd` presents the full 32-bit stored value on `reg_rdata` one cycle later, equal to the last value written.
- R3: Offset +0x4 of any window, offsets +0x4 to +0xC of the global slot, and any offset above the global register read as 0, and writes to them change nothing.
- R4: A window matches when bit 0 of its lower-bound register is 1 and `lk_addr[47:20]` lies between lower[31:4] and upper[31:4], both bounds included.
- R5: A window whose lower-bound bit 0 is 0 never matches, whatever its bounds.
- R6: When several enabled windows match, the window with the lowest index supplies the target.
- R7: When no enabled window matches, `lk_hit` is 0 and `lk_tgt` equals bits [3:0] of the global register.
- R8: On a match, `lk_hit` is 1 and `lk_tgt` equals bits [3:0] of the winning window's target register. Upper target bits are stored but do not affect routing.
- R9: Window 0 ignores writes. It reads back and decodes with its boot values: lower 0x00000001, upper 0x000000F0, target 0x00000007, covering 0x0 to 0xFFFFFF.
- R10: `lk_hit`, `lk_tgt` and `lk_done` update one cycle after a cycle with `lk_valid` high. `lk_done` is 0 in cycles that follow no request. The lookup sees the register contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Physical address to decode |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An enabled window matched |
| lk_tgt | output | 4 | Selected target identifier |

## Verification
Read data and lookup results are both due exactly one clock after their strobe. A write takes effect at the edge that samples it, so it is visible to any read or lookup issued after that edge. The bench drives each strobe on a falling edge and drops it on the next falling edge. It samples outputs at that same falling edge, half a period after the single register stage has loaded. Checks that a write was ignored follow the write with a readback or a lookup through the ports, issued once the write's edge has passed.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // sub-register select taken from byte offset bits [3:2]
  typedef enum logic [1:0] {
    SUB_LOWER = 2'd0,
    SUB_GAP   = 2'd1,
    SUB_UPPER = 2'd2,
    SUB_TGT   = 2'd3
  } sub_sel_e;
endpackage

// File: rtl/iowin_regfile.sv
module iowin_regfile
  import iowin_pkg::*;
#(
  parameter int    NUM_WIN    = 16,
  parameter int    FLD_W      = 28,
  parameter int    TGT_W      = 4,
  parameter int    REG_AW     = 9,
  parameter word_t BOOT_LOWER = 32'h0000_0001,
  parameter word_t BOOT_UPPER = 32'h0000_00F0,
  parameter word_t BOOT_TGT   = 32'h0000_0007
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  word_t             wdata,
  output word_t             rdata,
  output logic              win_en  [NUM_WIN],
  output logic [FLD_W-1:0]  win_lo  [NUM_WIN],
  output logic [FLD_W-1:0]  win_hi  [NUM_WIN],
  output logic [TGT_W-1:0]  win_tid [NUM_WIN],
  output logic [TGT_W-1:0]  dflt_tid
);
  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0] a_idx;
  sub_sel_e         a_sub;
  logic [1:0]       unused_lsb;

  assign a_idx      = addr[REG_AW-1:4];
  assign a_sub      = sub_sel_e'(addr[3:2]);
  assign unused_lsb = addr[1:0];

  word_t lower_q [NUM_WIN];
  word_t upper_q [NUM_WIN];
  word_t tgt_q   [NUM_WIN];
  word_t glob_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w == 0) begin : g_boot
      assign lower_q[w] = BOOT_LOWER;
      assign upper_q[w] = BOOT_UPPER;
      assign tgt_q[w]   = BOOT_TGT;
    end else begin : g_prog
      word_t lo_r, hi_r, tg_r;
      logic  sel;
      assign sel = wr_en && (a_idx == IDX_W'(w));
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_r <= '0;
          hi_r <= '0;
          tg_r <= '0;
        end else if (sel) begin
          case (a_sub)
            SUB_LOWER: lo_r <= wdata;
            SUB_UPPER: hi_r <= wdata;
            SUB_TGT:   tg_r <= wdata;
            default:   ;
          endcase
        end
      end
      assign lower_q[w] = lo_r;
      assign upper_q[w] = hi_r;
      assign tgt_q[w]   = tg_r;
    end
    assign win_en[w]  = lower_q[w][0];
    assign win_lo[w]  = lower_q[w][FLD_W+3:4];
    assign win_hi[w]  = upper_q[w][FLD_W+3:4];
    assign win_tid[w] = tgt_q[w][TGT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      glob_q <= '0;
    else if (wr_en && a_idx == IDX_W'(NUM_WIN) && a_sub == SUB_LOWER)
      glob_q <= wdata;
  end
  assign dflt_tid = glob_q[TGT_W-1:0];

  word_t rd_word;
  always_comb begin
    rd_word = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (a_idx == IDX_W'(w)) begin
        case (a_sub)
          SUB_LOWER: rd_word = lower_q[w];
          SUB_UPPER: rd_word = upper_q[w];
          SUB_TGT:   rd_word = tgt_q[w];
          default:   rd_word = '0;
        endcase
      end
    end
    if (a_idx == IDX_W'(NUM_WIN) && a_sub == SUB_LOWER)
      rd_word = glob_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_word;
  end

  // R3: the gap slot of every window reads as zero
  a_r3_gap_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[3:2] == 2'b01) |=> (rdata == '0));

  // R9: the boot window reads its fixed lower bound
  a_r9_boot_lower_fixed: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0) |=> (rdata == BOOT_LOWER));
endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
  parameter int NUM_WIN = 16,
  parameter int FLD_W   = 28
) (
  input  logic [FLD_W-1:0] key,
  input  logic             win_en [NUM_WIN],
  input  logic [FLD_W-1:0] win_lo [NUM_WIN],
  input  logic [FLD_W-1:0] win_hi [NUM_WIN],
  output logic [NUM_WIN-1:0] req
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic ge_lo, le_hi;
    assign ge_lo  = (key >= win_lo[w]);
    assign le_hi  = (key <= win_hi[w]);
    assign req[w] = win_en[w] && ge_lo && le_hi;
  end
endmodule

// File: rtl/iowin_prio.sv
module iowin_prio #(
  parameter int NUM_WIN = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_WIN-1:0] req,
  output logic [NUM_WIN-1:0] grant,
  output logic               any
);
  always_comb begin
    logic taken;
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
  assign any = |req;

  // R6: at most one window is granted
  a_r6_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R5: a grant only goes to a requesting window
  a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~req) == '0));

  // R6: nothing below the granted index is requesting
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (any |-> ((((grant - 1'b1) & req)) == '0)));
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int    NUM_WIN    = 16,
  parameter int    ADDR_W     = 48,
  parameter int    GRAN_SH    = 20,
  parameter int    TGT_W      = 4,
  parameter word_t BOOT_LOWER = 32'h0000_0001,
  parameter word_t BOOT_UPPER = 32'h0000_00F0,
  parameter word_t BOOT_TGT   = 32'h0000_0007,
  localparam int   FLD_W      = ADDR_W - GRAN_SH,
  localparam int   REG_AW     = $clog2(NUM_WIN + 1) + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [TGT_W-1:0]  lk_tgt
);
  logic             win_en  [NUM_WIN];
  logic [FLD_W-1:0] win_lo  [NUM_WIN];
  logic [FLD_W-1:0] win_hi  [NUM_WIN];
  logic [TGT_W-1:0] win_tid [NUM_WIN];
  logic [TGT_W-1:0] dflt_tid;
  logic [NUM_WIN-1:0] req, grant;
  logic any;
  logic [GRAN_SH-1:0] unused_offs;

  assign unused_offs = lk_addr[GRAN_SH-1:0];

  iowin_regfile #(
    .NUM_WIN(NUM_WIN), .FLD_W(FLD_W), .TGT_W(TGT_W), .REG_AW(REG_AW),
    .BOOT_LOWER(BOOT_LOWER), .BOOT_UPPER(BOOT_UPPER), .BOOT_TGT(BOOT_TGT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .win_en(win_en), .win_lo(win_lo),
    .win_hi(win_hi), .win_tid(win_tid), .dflt_tid(dflt_tid)
  );

  iowin_match #(.NUM_WIN(NUM_WIN), .FLD_W(FLD_W)) u_match (
    .key(lk_addr[ADDR_W-1:GRAN_SH]), .win_en(win_en), .win_lo(win_lo),
    .win_hi(win_hi), .req(req)
  );

  iowin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .clk(clk), .rst(rst), .req(req), .grant(grant), .any(any)
  );

  logic [TGT_W-1:0] sel_tid;
  always_comb begin
    sel_tid = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (grant[w]) sel_tid = sel_tid | win_tid[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_tgt  <= '0;
    end else begin
      lk_done <= lk_valid;
      if (lk_valid) begin
        lk_hit <= any;
        lk_tgt <= any ? sel_tid : dflt_tid;
      end
    end
  end

  // R4: the registered hit follows the window compare of the request cycle
  a_r4_hit_tracks_match: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (lk_hit == $past(|req)));

  // R7: a miss returns the global default target
  a_r7_miss_default: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !any) |=> (!lk_hit && lk_tgt == $past(dflt_tid)));

  // R10: results hold while no request is made
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> ($stable(lk_hit) && $stable(lk_tgt)));
endmodule

// File: tb/tb_io_window_decoder.sv
`timescale 1ns/1ps
module tb_io_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        lk_done, lk_hit;
  logic [3:0]  lk_tgt;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  io_window_decoder dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done),
    .lk_hit(lk_hit), .lk_tgt(lk_tgt)
  );

  // {address, expected hit, expected target}
  localparam logic [52:0] VEC [14] = '{
    {48'h0000_0000_0000, 1'b1, 4'h7},  // R9 boot window low edge
    {48'h0000_00FF_FFFF, 1'b1, 4'h7},  // R9 boot window top, inclusive
    {48'h0000_0100_0000, 1'b0, 4'hD},  // R7
    {48'h0001_0000_0000, 1'b1, 4'h3},  // R4 lower bound
    {48'h0000_FFFF_FFFF, 1'b0, 4'hD},  // R4 just below
    {48'h0001_0080_0000, 1'b1, 4'h3},  // R6 overlap, lower index
    {48'h0001_00FF_FFFF, 1'b1, 4'h3},  // R6
    {48'h0001_0100_0000, 1'b1, 4'h5},  // R4
    {48'h0001_01FF_FFFF, 1'b1, 4'h5},  // R4 upper bound inclusive
    {48'h0001_0200_0000, 1'b0, 4'hD},  // R4 just above
    {48'h0002_0000_0000, 1'b0, 4'hD},  // R5 disabled window
    {48'hFFFF_FFF0_0000, 1'b1, 4'hB},  // R8 top window, low nibble
    {48'hFFFF_FFFF_FFFF, 1'b1, 4'hB},  // R8
    {48'hFFFF_FFEF_FFFF, 1'b0, 4'hD}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic lk_chk(input string req, input logic [47:0] a, input logic h, input logic [3:0] t);
    @(negedge clk); lk_valid = 1'b1; lk_addr = a;
    @(negedge clk); lk_valid = 1'b0;
    check({req, " done"}, {31'b0, lk_done}, 32'd1);
    check({req, " hit"}, {31'b0, lk_hit}, {31'b0, h});
    check({req, " tgt"}, {28'b0, lk_tgt}, {28'b0, t});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 done", {31'b0, lk_done}, 32'h0);
    rd_chk("R1 win5 lower", 9'h050, 32'h0);
    rd_chk("R1 global", 9'h100, 32'h0);
    lk_chk("R1 miss default 0", 48'h0005_0000_0000, 1'b0, 4'h0);
    lk_chk("R9 boot decode", 48'h0000_0050_0000, 1'b1, 4'h7);

    // program the map (R2)
    wr(9'h010, 32'h0001_0001); wr(9'h018, 32'h0001_00F0); wr(9'h01C, 32'h0000_0003);
    wr(9'h020, 32'h0001_0081); wr(9'h028, 32'h0001_01F0); wr(9'h02C, 32'h0000_0005);
    wr(9'h030, 32'h0002_0000); wr(9'h038, 32'h0002_00F0); wr(9'h03C, 32'h0000_0009);
    wr(9'h0F0, 32'hFFFF_FFF1); wr(9'h0F8, 32'hFFFF_FFF0); wr(9'h0FC, 32'h0000_00AB);
    wr(9'h100, 32'h0000_0C4D);
    // R9 writes to window 0 ignored
    wr(9'h000, 32'h0000_0000); wr(9'h00C, 32'h0000_000E);
    // R3 writes to unmapped slots ignored
    wr(9'h014, 32'hDEAD_BEEF); wr(9'h104, 32'h1234_5678); wr(9'h110, 32'h5555_5555);

    rd_chk("R2 win1 lower", 9'h010, 32'h0001_0001);
    rd_chk("R2 win1 upper", 9'h018, 32'h0001_00F0);
    rd_chk("R2 win1 tgt", 9'h01C, 32'h0000_0003);
    rd_chk("R2 win15 lower", 9'h0F0, 32'hFFFF_FFF1);
    rd_chk("R8 win15 tgt full word", 9'h0FC, 32'h0000_00AB);
    rd_chk("R2 global", 9'h100, 32'h0000_0C4D);
    rd_chk("R3 gap", 9'h014, 32'h0);
    rd_chk("R3 global gap", 9'h104, 32'h0);
    rd_chk("R3 beyond", 9'h110, 32'h0);
    rd_chk("R9 win0 lower", 9'h000, 32'h0000_0001);
    rd_chk("R9 win0 upper", 9'h008, 32'h0000_00F0);
    rd_chk("R9 win0 tgt", 9'h00C, 32'h0000_0007);

    for (int i = 0; i < 14; i++)
      lk_chk($sformatf("R4/R5/R6/R7/R8 vec%0d", i), VEC[i][52:5], VEC[i][4], VEC[i][3:0]);

    // R5 enabling window 3 makes it match
    wr(9'h030, 32'h0002_0001);
    lk_chk("R5 enabled win3", 48'h0002_0000_0000, 1'b1, 4'h9);
    // R5 disabling window 1 exposes window 2 in the overlap
    wr(9'h010, 32'h0001_0000);
    lk_chk("R6 overlap after disable", 48'h0001_0080_0000, 1'b1, 4'h5);
    lk_chk("R5 disabled win1", 48'h0001_0000_0000, 1'b0, 4'hD);

    // R10 no request -> no done
    @(negedge clk);
    check("R10 idle done", {31'b0, lk_done}, 32'h0);
    // R10 lookup sees map before a same-cycle write
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 48'h0001_0000_0000;
    reg_wr = 1'b1; reg_addr = 9'h010; reg_wdata = 32'h0001_0001;
    @(negedge clk);
    lk_valid = 1'b0; reg_wr = 1'b0;
    check("R10 pre-write view", {31'b0, lk_hit}, 32'h0);
    lk_chk("R10 post-write view", 48'h0001_0000_0000, 1'b1, 4'h3);

    finished = 1;
    summary();
  end
endmodule